// File: doc/BRIEF.md
# Reset Supervisor with Activity Watchdog

This block produces a processor reset from three independent causes: a digital indication that the supply is above its threshold, a pair of manual reset pins of opposite polarity, and a watchdog that expects activity on a serial data line. Every cause is stretched into a reset pulse of a fixed length in clock cycles. Both reset polarities are driven, along with a flag that reports that reset is active.

All asynchronous inputs pass through a two-flop synchroniser. The manual pins then go through a glitch filter. They are edge-triggered: the active-high pin acts on its rising edge and the active-low pin on its falling edge. The watchdog restarts its count on any edge of the data line. It is held cleared for as long as reset is asserted. When it expires, it raises a reset like the other causes. A build parameter removes the watchdog completely.

Top module: `rstsup_top`

## Requirements
- R1: While the synchronised supply-ok input is low, `rst_o` is 1 and `rst_n_o` is 0. Out of chip reset (`rst_n` low), reset is asserted.
- R2: After `supply_ok_i` rises (driven before clock edge 1), `rst_o` stays 1 through edge POR_CYC+1 and drops to 0 at edge POR_CYC+2.
- R3: When `supply_ok_i` falls (driven before edge 1), `rst_o` is still 0 after edge 2 and is 1 after edge 3.
- R4: A rising edge on `mr_hi_i` that has passed the glitch filter asserts reset at edge GLITCH_CYC+3 and releases it at edge GLITCH_CYC+POR_CYC+3. A falling edge on `mr_hi_i` has no effect.
- R5: A falling edge on `mr_lo_n_i` that has passed the glitch filter asserts reset with the same timing as R4. A rising edge on `mr_lo_n_i` has no effect.
- R6: A manual input level that lasts fewer than GLITCH_CYC clock cycles is ignored. A level that lasts GLITCH_CYC cycles or more is accepted.
- R7: With the watchdog built in, if reset has been inactive for WDOG_CYC cycles with no edge on `wd_line_i`, reset asserts and then runs a full POR_CYC timeout.
- R8: Both a rising edge and a falling edge on `wd_line_i` restart the watchdog count.
- R9: While reset is asserted, the watchdog count stays at zero. After a release it restarts from zero, so a timeout cannot come before WDOG_CYC cycles.
- R10: A new trigger that arrives while a timeout is running restarts the timeout from zero.
- R11: `rst_n_o` is always the complement of `rst_o`, and `rst_act_o` always equals `rst_o`.
- R12: With WDOG_EN = 0, a quiet `wd_line_i` never causes a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| supply_ok_i | input | 1 | Supply above threshold indication (asynchronous) |
| mr_hi_i | input | 1 | Manual reset pin, acts on its rising edge |
| mr_lo_n_i | input | 1 | Manual reset pin, acts on its falling edge |
| wd_line_i | input | 1 | Data line watched for activity |
| rst_o | output | 1 | Reset output, active high |
| rst_n_o | output | 1 | Reset output, active low |
| rst_act_o | output | 1 | Reset-active flag |

## Verification
The case that is hardest to reach is proving that the watchdog is frozen during reset and that a falling edge alone can kick it. If either property is lost, the only visible sign is that a timeout comes a few dozen cycles early. The stimulus holds supply-ok low for longer than a watchdog period with the data line quiet. It then checks that the watchdog reset comes exactly WDOG_CYC cycles after the release. Later it leaves a single falling edge as the only kick inside a window that would otherwise expire. A second instance built without the watchdog shares the same inputs and must stay out of reset at the cycle where the first instance times out.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

    // Synchronised view of the asynchronous inputs
    typedef struct packed {
        logic sok;
        logic mr_hi;
        logic mr_lo_n;
        logic wd;
    } sup_in_t;

    // Inactive level of every input, used as synchroniser reset value
    localparam sup_in_t SUP_IN_IDLE = '{sok: 1'b0, mr_hi: 1'b0, mr_lo_n: 1'b1, wd: 1'b0};

endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync
    import rstsup_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sup_in_t d_i,
    output sup_in_t q_o
);

    typedef struct packed {
        sup_in_t st1;
        sup_in_t st2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.st1 = d_i;
        s_d.st2 = s_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st1: SUP_IN_IDLE, st2: SUP_IN_IDLE};
        else        s_q <= s_d;
    end

    assign q_o = s_q.st2;

endmodule

// File: rtl/rstsup_deglitch.sv
module rstsup_deglitch #(
    parameter int   GLITCH_CYC = 4,
    parameter logic IDLE_LVL   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_i,
    output logic filt_o
);

    localparam int CW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(GLITCH_CYC - 1);

    typedef struct packed {
        logic          filt;
        logic [CW-1:0] cnt;
    } dg_t;

    dg_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (s_i == g_q.filt) begin
            g_d.cnt = '0;
        end else if (g_q.cnt == CNT_LAST) begin
            g_d.filt = s_i;
            g_d.cnt  = '0;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{filt: IDLE_LVL, cnt: '0};
        else        g_q <= g_d;
    end

    assign filt_o = g_q.filt;

    // The filtered level moves only after the full run of mismatching samples
    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.cnt != CNT_LAST) |=> $stable(g_q.filt)); // R6

endmodule

// File: rtl/rstsup_wdog.sv
module rstsup_wdog #(
    parameter int WDOG_CYC = 100,
    parameter bit WDOG_EN  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic hold_i,
    output logic to_o
);

    generate
        if (WDOG_EN) begin : g_wd
            localparam int CW = $clog2(WDOG_CYC + 1);
            localparam logic [CW-1:0] CNT_LAST = CW'(WDOG_CYC - 1);

            typedef struct packed {
                logic          prev;
                logic [CW-1:0] cnt;
            } wd_t;

            wd_t  w_d, w_q;
            logic line_edge;
            logic expire;

            always_comb begin
                w_d       = w_q;
                line_edge = line_i ^ w_q.prev;
                expire    = !hold_i && !line_edge && (w_q.cnt == CNT_LAST);
                w_d.prev  = line_i;
                if (hold_i || line_edge || expire) w_d.cnt = '0;
                else                               w_d.cnt = w_q.cnt + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) w_q <= '{prev: 1'b0, cnt: '0};
                else        w_q <= w_d;
            end

            assign to_o = expire;

            AST_WD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                hold_i |=> (w_q.cnt == '0)); // R9
            AST_WD_KICK: assert property (@(posedge clk) disable iff (!rst_n)
                (line_i != w_q.prev) |=> (w_q.cnt == '0)); // R8
        end else begin : g_nowd
            logic unused_wd;
            assign unused_wd = ^{clk, rst_n, line_i, hold_i};
            assign to_o      = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/rstsup_top.sv
module rstsup_top
    import rstsup_pkg::*;
#(
    parameter int GLITCH_CYC = 4,
    parameter int POR_CYC    = 32,
    parameter int WDOG_CYC   = 100,
    parameter bit WDOG_EN    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic mr_hi_i,
    input  logic mr_lo_n_i,
    input  logic wd_line_i,
    output logic rst_o,
    output logic rst_n_o,
    output logic rst_act_o
);

    localparam int CW = $clog2(POR_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(POR_CYC - 1);

    typedef struct packed {
        logic          hi_prev;
        logic          lo_prev;
        logic          rst;
        logic [CW-1:0] cnt;
    } sv_t;

    sup_in_t raw, syn;
    logic    hi_f, lo_f, wd_to, trig;
    sv_t     v_d, v_q;

    assign raw = '{sok: supply_ok_i, mr_hi: mr_hi_i, mr_lo_n: mr_lo_n_i, wd: wd_line_i};

    rstsup_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    rstsup_deglitch #(.GLITCH_CYC(GLITCH_CYC), .IDLE_LVL(1'b0)) u_dg_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .s_i    (syn.mr_hi),
        .filt_o (hi_f)
    );

    rstsup_deglitch #(.GLITCH_CYC(GLITCH_CYC), .IDLE_LVL(1'b1)) u_dg_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .s_i    (syn.mr_lo_n),
        .filt_o (lo_f)
    );

    rstsup_wdog #(.WDOG_CYC(WDOG_CYC), .WDOG_EN(WDOG_EN)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (syn.wd),
        .hold_i (v_q.rst),
        .to_o   (wd_to)
    );

    always_comb begin
        v_d         = v_q;
        v_d.hi_prev = hi_f;
        v_d.lo_prev = lo_f;
        trig        = (hi_f && !v_q.hi_prev) || (!lo_f && v_q.lo_prev) || wd_to;
        if (!syn.sok || trig) begin
            v_d.rst = 1'b1;
            v_d.cnt = '0;
        end else if (v_q.rst) begin
            if (v_q.cnt == CNT_LAST) begin
                v_d.rst = 1'b0;
                v_d.cnt = '0;
            end else begin
                v_d.cnt = v_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '{hi_prev: 1'b0, lo_prev: 1'b1, rst: 1'b1, cnt: '0};
        else        v_q <= v_d;
    end

    assign rst_o     = v_q.rst;
    assign rst_n_o   = ~v_q.rst;
    assign rst_act_o = v_q.rst;

    AST_SOK_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !syn.sok |=> (v_q.rst && v_q.cnt == '0)); // R1
    AST_RELEASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(v_q.rst) |-> ($past(v_q.cnt) == CNT_LAST)); // R2
    AST_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && syn.sok) |=> (v_q.rst && v_q.cnt == '0)); // R10

endmodule

// File: tb/rstsup_top_tb.sv
module rstsup_top_tb;

    localparam int G = 4;
    localparam int P = 32;
    localparam int W = 100;

    typedef struct {
        int    cyc;
        bit    val;
        bit    which;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sok = 1'b0, mr_hi = 1'b0, mr_lo_n = 1'b1, wd = 1'b0;
    logic r0, rn0, ra0, r1, rn1, ra1;
    int   cyc = 0;
    int   n_tests = 0, n_fail = 0;
    int   kc = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rstsup_top #(.GLITCH_CYC(G), .POR_CYC(P), .WDOG_CYC(W), .WDOG_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(sok), .mr_hi_i(mr_hi),
        .mr_lo_n_i(mr_lo_n), .wd_line_i(wd), .rst_o(r0), .rst_n_o(rn0), .rst_act_o(ra0));

    rstsup_top #(.GLITCH_CYC(G), .POR_CYC(P), .WDOG_CYC(W), .WDOG_EN(1'b0)) u_dut_nowd (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(sok), .mr_hi_i(mr_hi),
        .mr_lo_n_i(mr_lo_n), .wd_line_i(wd), .rst_o(r1), .rst_n_o(rn1), .rst_act_o(ra1));

    // Driver side: queue an expected reset level at an absolute cycle
    task automatic expect_at(input int at, input bit val, input bit which, input string req);
        exp_t e;
        e.cyc = at; e.val = val; e.which = which; e.req = req;
        sb.push_back(e);
    endtask

    task automatic expect_both(input int at, input bit val, input string req);
        expect_at(at, val, 1'b0, req);
        expect_at(at, val, 1'b1, req);
    endtask

    // Wait n cycles, optionally kicking the data line every 25 cycles
    task automatic step(input int n, input bit kick);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (kick) begin
                kc++;
                if (kc % 25 == 0) wd = ~wd;
            end
        end
    endtask

    // Monitor side: pop and compare at the scheduled cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            logic a, an, af;
            e = sb.pop_front();
            a  = e.which ? r1  : r0;
            an = e.which ? rn1 : rn0;
            af = e.which ? ra1 : ra0;
            n_tests++;
            if (e.cyc != cyc || a !== e.val) begin
                n_fail++;
                $display("FAIL %s: dut%0d cycle %0d (sched %0d) rst_o=%0b expected %0b",
                         e.req, e.which, cyc, e.cyc, a, e.val);
            end
            n_tests++;
            if (an !== ~a || af !== a) begin
                n_fail++;
                $display("FAIL R11: dut%0d cycle %0d rst_n_o=%0b rst_act_o=%0b expected %0b/%0b",
                         e.which, cyc, an, af, ~a, a);
            end
        end
    end

    initial begin
        int c, e_rel, f_rel, d;
        step(3, 1'b0);
        rst_n = 1'b1;
        c = cyc;
        // R1: reset state and hold while supply low (longer than a watchdog period)
        expect_both(c + 1, 1'b1, "R1");
        expect_both(c + 150, 1'b1, "R1");
        step(150, 1'b0);

        // R2: power-up timeout; R9/R7/R12 watchdog after release
        c = cyc;
        sok = 1'b1;
        expect_both(c + 1 + P, 1'b1, "R2");
        expect_both(c + 2 + P, 1'b0, "R2");
        e_rel = c + 2 + P;
        expect_at(e_rel + W - 1, 1'b0, 1'b0, "R9");
        expect_at(e_rel + W, 1'b1, 1'b0, "R7");
        expect_at(e_rel + W, 1'b0, 1'b1, "R12");
        f_rel = e_rel + W + P;
        expect_at(f_rel - 1, 1'b1, 1'b0, "R7");
        expect_at(f_rel, 1'b0, 1'b0, "R7");
        step(f_rel + 1 - cyc, 1'b0);

        // R8: rising kick, then a lone falling kick extends the window
        c = cyc;
        wd = 1'b1;
        expect_both(c + 110, 1'b0, "R8");
        expect_both(c + 150, 1'b0, "R8");
        step(60, 1'b0);
        wd = 1'b0;
        step(90, 1'b0);
        wd = 1'b1;
        kc = 0;

        // R6: short pulses on both manual pins are ignored
        step(5, 1'b1);
        c = cyc;
        mr_hi = 1'b1;
        expect_both(c + G + 10, 1'b0, "R6");
        step(G - 1, 1'b1);
        mr_hi = 1'b0;
        step(G + 12, 1'b1);
        c = cyc;
        mr_lo_n = 1'b0;
        expect_both(c + G + 10, 1'b0, "R6");
        step(G - 1, 1'b1);
        mr_lo_n = 1'b1;
        step(G + 12, 1'b1);

        // R4: accepted rising edge on active-high pin; later falling edge ignored
        c = cyc;
        mr_hi = 1'b1;
        expect_both(c + 2 + G, 1'b0, "R4");
        expect_both(c + 3 + G, 1'b1, "R4");
        expect_both(c + 2 + G + P, 1'b1, "R4");
        expect_both(c + 3 + G + P, 1'b0, "R4");
        step(5 + G + P, 1'b1);
        d = cyc;
        mr_hi = 1'b0;
        expect_both(d + G + 10, 1'b0, "R4");
        step(G + 12, 1'b1);

        // R5: accepted falling edge on active-low pin; later rising edge ignored
        c = cyc;
        mr_lo_n = 1'b0;
        expect_both(c + 2 + G, 1'b0, "R5");
        expect_both(c + 3 + G, 1'b1, "R5");
        expect_both(c + 2 + G + P, 1'b1, "R5");
        expect_both(c + 3 + G + P, 1'b0, "R5");
        step(5 + G + P, 1'b1);
        d = cyc;
        mr_lo_n = 1'b1;
        expect_both(d + G + 10, 1'b0, "R5");
        step(G + 12, 1'b1);

        // R10: second trigger during the timeout restarts it
        c = cyc;
        mr_hi = 1'b1;
        expect_both(c + 3 + G + P, 1'b1, "R10");
        expect_both(c + 22 + G + P, 1'b1, "R10");
        expect_both(c + 23 + G + P, 1'b0, "R10");
        step(G + 2, 1'b1);
        mr_hi = 1'b0;
        step(20 - (G + 2), 1'b1);
        mr_hi = 1'b1;
        step(G + 2, 1'b1);
        mr_hi = 1'b0;
        step(c + 25 + G + P - cyc, 1'b1);

        // R3: supply drop response, then recovery
        c = cyc;
        sok = 1'b0;
        expect_both(c + 2, 1'b0, "R3");
        expect_both(c + 3, 1'b1, "R3");
        step(6, 1'b1);
        c = cyc;
        sok = 1'b1;
        expect_both(c + 1 + P, 1'b1, "R2");
        expect_both(c + 2 + P, 1'b0, "R2");
        step(P + 5, 1'b1);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
        end
        if (sb.size() > 0) begin
            n_tests += sb.size();
            n_fail  += sb.size();
            $display("FAIL scoreboard: %0d expectations left, expected 0", sb.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule